// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps time of day and calendar date in packed BCD fields. The fields are hundredths, seconds, minutes, hours, date, month, two-digit year and day of week. A one-cycle enable at 100 Hz, derived from a 32.768 kHz timebase elsewhere, drives it. All rollovers ripple through the fields in the same clock cycle as the tick. Bit 7 of the hour byte selects the hour format. When it is 1 the hour runs 00 to 23. When it is 0 the hour runs 12, 01 to 11, and bit 5 marks PM.

Software-facing logic sees the time through two ports. A snapshot strobe freezes a coherent copy of every field into a holding register, and the counters keep running behind it. A load strobe commits a whole new time in a single cycle and sets hundredths to 00. The load also restarts the phase of the 1 Hz output. After reset, which models a loss of all power, the counters stay frozen until the first load.

The time word is 64 bits, one byte per field. From the least significant byte up, the order is hundredths, seconds, minutes, hour, date, month, year and day of week.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset the snapshot word is 0 and `pps_o` is 0. Ticks have no effect until the first load, so a snapshot taken then reads hour 00, minutes 00, seconds 00, hundredths 00, date 01, month 01, year 00 and day 0.
- R2: On each tick taken after a load, hundredths advance in BCD from 00 to 99. From 99 they wrap to 00 and advance seconds. Seconds wrap from 59 to 00 and advance minutes, and minutes wrap from 59 to 00 and advance the hour.
- R3: With hour bit 7 set (24-hour format), the hour advances 00 to 23. From 23 it wraps to 00 (hour byte 0x80) and advances the date.
- R4: With hour bit 7 clear (12-hour format, bit 5 = PM), the hour runs as follows. 11 AM becomes 12 PM (byte 0x32). 12 becomes 01 and keeps the PM bit. 11 PM becomes 12 AM (byte 0x12) and advances the date.
- R5: The date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, after 31 in the other long months, and after 28 in a February whose year is not a multiple of 4.
- R6: February runs to 29 when the two-digit year is divisible by 4, and year 00 counts as divisible. No century rule applies.
- R7: Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00.
- R8: Day of week (bits 2:0 of the top byte) advances on every date advance, counts 0 to 6 and wraps to 0. It never changes otherwise, except by load.
- R9: A snapshot strobe copies the field values held at that clock edge, before any tick in the same cycle takes effect. The copy stays unchanged until the next strobe.
- R10: A load copies every field except hundredths, which become 00. The loaded value masks are: seconds and minutes 7 bits, hour bits 7 and 5:0, date 6 bits, month 5 bits, year 8 bits, day 3 bits. A load takes priority over a tick in the same cycle.
- R11: While running, `pps_o` is 1 when hundredths are 00 to 49 and 0 when they are 50 to 99. It is therefore 1 in the cycle after a load.
- R12: A loaded out-of-range value is not corrected. Each field steps by BCD increment until it equals its terminal value; for example, minutes loaded as 61 become 62 at the next minute carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 100 Hz advance enable |
| load_i | input | 1 | Commit `load_time_i` to the counters |
| load_time_i | input | 64 | New time word; hundredths byte ignored |
| snap_i | input | 1 | Freeze the current time into the snapshot |
| snap_time_o | output | 64 | Frozen time word |
| pps_o | output | 1 | 1 Hz square output, restarts on load |

## Verification
On every cycle, the assertions check the following:
- the counters hold still before the first load;
- a load lands exactly as the masked input, with hundredths at 00, and raises `pps_o`;
- the hundredths byte stays legal BCD;
- the day of week moves only on a date advance;
- the snapshot captures the prior live value and otherwise holds.

Only the bench scenarios can show the calendar arithmetic. That covers the month lengths, the leap rule, the 12-hour AM/PM sequence, the year and week wraps, the 1 Hz duty split and the uncorrected stepping of out-of-range loads.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_W = 8;
  localparam int NUM_FIELDS = 8;
  localparam int TIME_W = FIELD_W * NUM_FIELDS;

  // bytes of the time word that hold state; hundredths never loaded
  localparam logic [TIME_W-1:0] LOAD_MASK = 64'h07FF_1F3F_BF7F_7F00;

  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [5:0] month_last_day(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return leap_year(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int           W     = 8,
  parameter logic [W-1:0] FIRST = '0,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  logic [W-1:0] val_q;
  logic [7:0]   inc_w;
  logic         at_last;

  assign inc_w   = rtc_pkg::bcd_inc8(8'(val_q));
  assign at_last = (val_q == last_i);
  assign wrap_o  = step_i & at_last;
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST;
    else if (load_i) val_q <= load_val_i;
    else if (step_i) val_q <= at_last ? FIRST : inc_w[W-1:0];
  end
endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       step_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  logic [7:0] hr_q, hr_d, inc24, inc12;
  logic       mode24, pm, carry;
  logic [4:0] h12;
  logic [5:0] h24;

  assign mode24 = hr_q[7];
  assign pm     = hr_q[5];
  assign h12    = hr_q[4:0];
  assign h24    = hr_q[5:0];
  assign inc24  = rtc_pkg::bcd_inc8({2'b00, h24});
  assign inc12  = rtc_pkg::bcd_inc8({3'b000, h12});

  always_comb begin
    carry = 1'b0;
    if (mode24) begin
      if (h24 == 6'h23) begin
        hr_d  = 8'h80;
        carry = 1'b1;
      end else begin
        hr_d = {2'b10, inc24[5:0]};
      end
    end else begin
      if (h12 == 5'h12) begin
        hr_d = {2'b00, pm, 5'h01};
      end else if (h12 == 5'h11) begin
        hr_d  = {2'b00, ~pm, 5'h12};
        carry = pm;  // 11 PM -> 12 AM is the day boundary
      end else begin
        hr_d = {2'b00, pm, inc12[4:0]};
      end
    end
  end

  assign carry_o = step_i & carry;
  assign val_o   = hr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hr_q <= 8'h00;
    else if (load_i) hr_q <= load_val_i & 8'hBF;
    else if (step_i) hr_q <= hr_d;
  end
endmodule

// File: rtl/rtc_snap_latch.sv
module rtc_snap_latch #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         snap_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] held_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_o <= '0;
    else if (snap_i) held_o <= live_i;
  end
endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import rtc_pkg::*;
#(
  parameter int PPS_HALF = 8'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_time_i,
  input  logic              snap_i,
  output logic [TIME_W-1:0] snap_time_o,
  output logic              pps_o
);
  localparam logic [7:0] PPS_SPLIT = PPS_HALF[7:0];

  logic       run_q, adv;
  logic [7:0] hs_v, yr_v, hr_v;
  logic [6:0] sc_v, mn_v;
  logic [5:0] dt_v, dt_last;
  logic [4:0] mo_v;
  logic [2:0] dw_v;
  logic       hs_wrap, sc_wrap, mn_wrap, hr_carry, dt_wrap, mo_wrap;
  logic       yr_wrap, dw_wrap;
  logic [TIME_W-1:0] live_time;

  // frozen after power loss until the first commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 1'b0;
    else if (load_i) run_q <= 1'b1;
  end

  assign adv     = tick_i & run_q & ~load_i;
  assign dt_last = month_last_day(mo_v, yr_v);

  rtc_bcd_field #(.W(8), .FIRST(8'h00), .RST(8'h00)) u_hs (
    .clk_i, .rst_ni, .load_i, .load_val_i(8'h00), .step_i(adv),
    .last_i(8'h99), .val_o(hs_v), .wrap_o(hs_wrap));

  rtc_bcd_field #(.W(7), .FIRST(7'h00), .RST(7'h00)) u_sc (
    .clk_i, .rst_ni, .load_i, .load_val_i(load_time_i[14:8]), .step_i(hs_wrap),
    .last_i(7'h59), .val_o(sc_v), .wrap_o(sc_wrap));

  rtc_bcd_field #(.W(7), .FIRST(7'h00), .RST(7'h00)) u_mn (
    .clk_i, .rst_ni, .load_i, .load_val_i(load_time_i[22:16]), .step_i(sc_wrap),
    .last_i(7'h59), .val_o(mn_v), .wrap_o(mn_wrap));

  rtc_hour_field u_hr (
    .clk_i, .rst_ni, .load_i, .load_val_i(load_time_i[31:24]), .step_i(mn_wrap),
    .val_o(hr_v), .carry_o(hr_carry));

  rtc_bcd_field #(.W(6), .FIRST(6'h01), .RST(6'h01)) u_dt (
    .clk_i, .rst_ni, .load_i, .load_val_i(load_time_i[37:32]), .step_i(hr_carry),
    .last_i(dt_last), .val_o(dt_v), .wrap_o(dt_wrap));

  rtc_bcd_field #(.W(5), .FIRST(5'h01), .RST(5'h01)) u_mo (
    .clk_i, .rst_ni, .load_i, .load_val_i(load_time_i[44:40]), .step_i(dt_wrap),
    .last_i(5'h12), .val_o(mo_v), .wrap_o(mo_wrap));

  rtc_bcd_field #(.W(8), .FIRST(8'h00), .RST(8'h00)) u_yr (
    .clk_i, .rst_ni, .load_i, .load_val_i(load_time_i[55:48]), .step_i(mo_wrap),
    .last_i(8'h99), .val_o(yr_v), .wrap_o(yr_wrap));

  rtc_bcd_field #(.W(3), .FIRST(3'd0), .RST(3'd0)) u_dw (
    .clk_i, .rst_ni, .load_i, .load_val_i(load_time_i[58:56]), .step_i(hr_carry),
    .last_i(3'd6), .val_o(dw_v), .wrap_o(dw_wrap));

  assign live_time = {5'b0, dw_v, yr_v, 3'b0, mo_v, 2'b0, dt_v, hr_v,
                      1'b0, mn_v, 1'b0, sc_v, hs_v};

  rtc_snap_latch #(.W(TIME_W)) u_snap (
    .clk_i, .rst_ni, .snap_i, .live_i(live_time), .held_o(snap_time_o));

  assign pps_o = run_q & (hs_v < PPS_SPLIT);
endmodule

// File: rtl/bcd_clock_calendar_chk.sv
module bcd_clock_calendar_chk
  import rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [TIME_W-1:0] load_time_i,
  input logic              snap_i,
  input logic [TIME_W-1:0] snap_time_o,
  input logic              pps_o,
  input logic [TIME_W-1:0] live_time_i,
  input logic              run_i,
  input logic              day_step_i
);
  p_stopped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(live_time_i));

  p_hund_bcd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_time_i[7:4] <= 4'd9) && (live_time_i[3:0] <= 4'd9));

  p_dow_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !day_step_i) |=> $stable(live_time_i[58:56]));

  p_snap_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (snap_time_o == $past(live_time_i)));

  p_snap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_time_o));

  p_load_value_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (live_time_i == ($past(load_time_i) & LOAD_MASK)));

  p_pps_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pps_o);
endmodule

bind bcd_clock_calendar bcd_clock_calendar_chk u_chk (
  .clk_i, .rst_ni, .load_i, .load_time_i, .snap_i, .snap_time_o, .pps_o,
  .live_time_i(live_time), .run_i(run_q), .day_step_i(hr_carry));

// File: tb/bcd_clock_calendar_tb.sv
module bcd_clock_calendar_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        load_i = 1'b0;
  logic [63:0] load_time_i = '0;
  logic        snap_i = 1'b0;
  logic [63:0] snap_time_o;
  logic        pps_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bcd_clock_calendar u_dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [63:0] tp(input logic [7:0] dw, yr, mo, dt, hr, mn, sc, hs);
    return {dw, yr, mo, dt, hr, mn, sc, hs};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i) tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic load(input logic [63:0] v);
    @(negedge clk_i) begin load_i = 1'b1; load_time_i = v; end
    @(negedge clk_i) load_i = 1'b0;
  endtask

  task automatic snap();
    @(negedge clk_i) snap_i = 1'b1;
    @(negedge clk_i) snap_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 snapshot after reset", snap_time_o, '0);
    chk("R1 pps after reset", 64'(pps_o), 64'd0);
    ticks(50);
    snap();
    chk("R1 stopped before load", snap_time_o, tp(8'h0, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
    chk("R1 pps stays low", 64'(pps_o), 64'd0);
  endtask

  task automatic t_basic();
    load(tp(8'h2, 8'h24, 8'h03, 8'h15, 8'h90, 8'h59, 8'h59, 8'h55));
    chk("R11 pps high after load", 64'(pps_o), 64'd1);
    snap();
    chk("R10 load value, hundredths 00", snap_time_o, tp(8'h2, 8'h24, 8'h03, 8'h15, 8'h90, 8'h59, 8'h59, 8'h00));
    ticks(49);
    snap();
    chk("R2 hundredths 49", snap_time_o[7:0], 64'h49);
    chk("R11 pps high at 49", 64'(pps_o), 64'd1);
    ticks(1);
    chk("R11 pps low at 50", 64'(pps_o), 64'd0);
    ticks(50);
    snap();
    chk("R2 cascade to hour", snap_time_o, tp(8'h2, 8'h24, 8'h03, 8'h15, 8'h91, 8'h00, 8'h00, 8'h00));
    chk("R11 pps high at 00", 64'(pps_o), 64'd1);
  endtask

  task automatic t_load_prio();
    ticks(30);
    @(negedge clk_i) begin
      load_i = 1'b1; tick_i = 1'b1;
      load_time_i = tp(8'h1, 8'h10, 8'h07, 8'h04, 8'h85, 8'h30, 8'h20, 8'h00);
    end
    @(negedge clk_i) begin load_i = 1'b0; tick_i = 1'b0; end
    snap();
    chk("R10 load beats tick", snap_time_o, tp(8'h1, 8'h10, 8'h07, 8'h04, 8'h85, 8'h30, 8'h20, 8'h00));
  endtask

  task automatic t_24h_wrap();
    load(tp(8'h6, 8'h99, 8'h12, 8'h31, 8'hA3, 8'h59, 8'h59, 8'h00));
    ticks(100);
    snap();
    chk("R3 R7 R8 full wrap", snap_time_o, tp(8'h0, 8'h00, 8'h01, 8'h01, 8'h80, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_12h();
    load(tp(8'h1, 8'h24, 8'h05, 8'h10, 8'h11, 8'h59, 8'h59, 8'h00));
    ticks(100);
    snap();
    chk("R4 11 AM to 12 PM", snap_time_o, tp(8'h1, 8'h24, 8'h05, 8'h10, 8'h32, 8'h00, 8'h00, 8'h00));
    load(tp(8'h1, 8'h24, 8'h05, 8'h10, 8'h32, 8'h59, 8'h59, 8'h00));
    ticks(100);
    snap();
    chk("R4 12 PM to 01 PM", snap_time_o[31:24], 64'h21);
    load(tp(8'h3, 8'h24, 8'h05, 8'h10, 8'h31, 8'h59, 8'h59, 8'h00));
    ticks(100);
    snap();
    chk("R4 11 PM to 12 AM next day", snap_time_o, tp(8'h4, 8'h24, 8'h05, 8'h11, 8'h12, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic day_end(input logic [7:0] yr, mo, dt, input logic [63:0] exp, input string req);
    load(tp(8'h0, yr, mo, dt, 8'hA3, 8'h59, 8'h59, 8'h00));
    ticks(100);
    snap();
    chk(req, snap_time_o, exp);
  endtask

  task automatic t_months();
    day_end(8'h24, 8'h04, 8'h30, tp(8'h1, 8'h24, 8'h05, 8'h01, 8'h80, 8'h00, 8'h00, 8'h00), "R5 April ends at 30");
    day_end(8'h24, 8'h01, 8'h30, tp(8'h1, 8'h24, 8'h01, 8'h31, 8'h80, 8'h00, 8'h00, 8'h00), "R5 January reaches 31");
    day_end(8'h23, 8'h02, 8'h28, tp(8'h1, 8'h23, 8'h03, 8'h01, 8'h80, 8'h00, 8'h00, 8'h00), "R5 February 23 ends at 28");
    day_end(8'h24, 8'h02, 8'h28, tp(8'h1, 8'h24, 8'h02, 8'h29, 8'h80, 8'h00, 8'h00, 8'h00), "R6 February 24 reaches 29");
    day_end(8'h24, 8'h02, 8'h29, tp(8'h1, 8'h24, 8'h03, 8'h01, 8'h80, 8'h00, 8'h00, 8'h00), "R6 February 24 ends at 29");
    day_end(8'h00, 8'h02, 8'h28, tp(8'h1, 8'h00, 8'h02, 8'h29, 8'h80, 8'h00, 8'h00, 8'h00), "R6 year 00 is leap");
  endtask

  task automatic t_snapshot();
    logic [63:0] held;
    load(tp(8'h0, 8'h24, 8'h06, 8'h01, 8'h88, 8'h00, 8'h10, 8'h00));
    snap();
    held = snap_time_o;
    ticks(300);
    chk("R9 snapshot holds while running", snap_time_o, held);
    snap();
    chk("R9 new snapshot advanced", snap_time_o, tp(8'h0, 8'h24, 8'h06, 8'h01, 8'h88, 8'h00, 8'h13, 8'h00));
    @(negedge clk_i) begin snap_i = 1'b1; tick_i = 1'b1; end
    @(negedge clk_i) begin snap_i = 1'b0; tick_i = 1'b0; end
    chk("R9 snapshot taken before same-cycle tick", snap_time_o[15:0], 64'h1300);
  endtask

  task automatic t_out_of_range();
    load(tp(8'h0, 8'h24, 8'h06, 8'h01, 8'h90, 8'h61, 8'h59, 8'h00));
    ticks(100);
    snap();
    chk("R12 minutes 61 step to 62", snap_time_o, tp(8'h0, 8'h24, 8'h06, 8'h01, 8'h90, 8'h62, 8'h00, 8'h00));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_load_prio();
    t_24h_wrap();
    t_12h();
    t_months();
    t_snapshot();
    t_out_of_range();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule